// File: doc/BRIEF.md
# Composite Sync Separator and Normaliser

This block takes a sampled horizontal or composite sync signal whose polarity is not known in advance. It turns that signal into three outputs for a line-locking loop further down the chip: a positive horizontal pulse with a fixed delay from the incoming leading edge, an extracted vertical sync flag, and an inhibit that holds a downstream phase comparator idle. The input passes through a synchroniser. After that, every quantity is a count of sample clocks: high-run and low-run lengths, pulse widths, and the spacing between accepted line edges.

The block decides polarity by majority over consecutive lines. The level with the shorter run is taken as the active level, and the decision needs several agreeing lines before it changes. A pulse counts as a line edge only if it survives a minimum-width filter and arrives in the last quarter of the expected line period. The expected period is a running average of accepted spacings. This keeps mid-line equalizing pulses and glitches out of the horizontal output. A pulse wider than a quarter of the expected period counts as a broad vertical serration. Two broad pulses in a row raise the vertical flag, and two accepted normal pulses in a row clear it. A controller can force the inhibit high at any time.

Top module: `csync_normalizer`

## Requirements
- R1: `hs_o` rises exactly SYNC_STAGES+MIN_W (default 6) clock cycles after the first clock edge that samples the active input level. It stays high for HS_W (default 8) cycles.
- R2: After reset the active level is high. At each rising edge of the synchronised input, the high run before it is compared with the low run that just ended. If the high run is not shorter, that line votes for active-low. POL_LINES (default 4) consecutive votes against the current polarity invert it.
- R3: Fewer than POL_LINES consecutive contrary votes leave the polarity unchanged. Any agreeing vote clears the count.
- R4: An active pulse shorter than MIN_W samples produces no `hs_o` pulse and has no effect on the vertical-sync counters.
- R5: A qualified leading edge produces `hs_o` only when the spacing to the previous accepted edge is at least the period estimate minus a quarter of it. Otherwise the pulse is dropped as equalizing.
- R6: The period estimate starts at LINE_NOM. On each accepted edge whose spacing did not saturate the spacing counter, the estimate moves by (spacing − estimate) arithmetically shifted right by AVG_SH (default 3).
- R7: A pulse of at least MIN_W samples whose width times 4 exceeds the period estimate is broad. `vs_o` rises after V_ENTER (default 2) broad pulses with no accepted normal pulse between them.
- R8: `vs_o` falls after V_EXIT (default 2) consecutive accepted normal-width pulses. Rejected normal-width pulses neither count nor break the run.
- R9: `inh_o` is high whenever `vs_o` or `ext_inh_i` is high, with no cycle of delay from `ext_inh_i`.
- R10: During and right after reset, `hs_o`, `vs_o` and `inh_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Raw horizontal or composite sync, either polarity |
| ext_inh_i | input | 1 | Controller request to hold the phase comparator off |
| hs_o | output | 1 | Normalised horizontal pulse, active high |
| vs_o | output | 1 | Extracted vertical sync flag |
| inh_o | output | 1 | Phase comparator inhibit |

## Verification
Two functions can be active in the same cycle: horizontal pulse generation and the inhibit path. During a vertical interval, the line-start edge of a broad serration still qualifies. Its `hs_o` pulse therefore falls in cycles where `inh_o` is already high from `vs_o`. The bench drives a third broad line with `ext_inh_i` also raised and checks both the exact `hs_o` cycle and the inhibit level. It then drops `ext_inh_i` and confirms that `inh_o` stays high on the vertical flag alone. The bench also triggers a polarity flip and a period change while horizontal output is still expected. It scores every `hs_o` edge against a queue of cycles derived from the stimulus.

// File: rtl/csn_pkg.sv
package csn_pkg;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_NOISE,
        KIND_LINE,
        KIND_BROAD
    } pulse_kind_e;

    // Width classification of one finished active pulse
    function automatic pulse_kind_e classify_width(input logic [31:0] width,
                                                   input logic [31:0] period,
                                                   input logic [31:0] min_width);
        if (width < min_width)
            return KIND_NOISE;
        else if ((width << 2) > period)
            return KIND_BROAD;
        else
            return KIND_LINE;
    endfunction

endpackage

// File: rtl/csn_sync2.sv
module csn_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/csn_polarity.sv
module csn_polarity #(
    parameter int CNT_W     = 12,
    parameter int POL_LINES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic s_i,
    output logic act_o
);
    localparam int VW = $clog2(POL_LINES + 1);

    typedef struct packed {
        logic             s;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] hi_len;
        logic             neg;
        logic [VW-1:0]    votes;
    } pol_st_t;

    pol_st_t q, d;
    logic    rise, want_neg;

    always_comb begin
        d        = q;
        d.s      = s_i;
        rise     = s_i & ~q.s;
        // low run just ended is q.run at a rising edge
        want_neg = (q.hi_len >= q.run);
        if (s_i != q.s) begin
            d.run = CNT_W'(1);
            if (q.s) d.hi_len = q.run;
        end else if (q.run != '1) begin
            d.run = q.run + CNT_W'(1);
        end
        if (rise) begin
            if (want_neg != q.neg) begin
                if (q.votes == VW'(POL_LINES - 1)) begin
                    d.neg   = ~q.neg;
                    d.votes = '0;
                end else begin
                    d.votes = q.votes + VW'(1);
                end
            end else begin
                d.votes = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign act_o = s_i ^ q.neg;

    // R2: polarity moves only on a rising edge of the synchronised input
    a_r2_flip_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(q.neg) |-> $past(rise));

    // R3: a flip needs the full count of contrary votes before it
    a_r3_flip_after_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(q.neg) |-> $past(q.votes) == VW'(POL_LINES - 1));
endmodule

// File: rtl/csn_window.sv
module csn_window #(
    parameter int CNT_W    = 12,
    parameter int LINE_NOM = 100,
    parameter int AVG_SH   = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             accept_i,
    output logic             win_open_o,
    output logic [CNT_W-1:0] avg_o
);
    localparam int SW = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] since;
        logic [CNT_W-1:0] avg;
    } win_st_t;

    win_st_t q, d;
    logic [CNT_W:0]          since_plus;
    logic [CNT_W-1:0]        thr;
    logic signed [CNT_W+1:0] diff, step;

    always_comb begin
        d          = q;
        since_plus = {1'b0, q.since} + SW'(1);
        thr        = q.avg - (q.avg >> 2);
        win_open_o = (since_plus >= {1'b0, thr});
        diff       = $signed({1'b0, since_plus}) - $signed({2'b00, q.avg});
        step       = diff >>> AVG_SH;
        if (accept_i) begin
            d.since = '0;
            if (q.since != '1)
                d.avg = CNT_W'($signed({2'b00, q.avg}) + step);
        end else if (q.since != '1) begin
            d.since = q.since + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.since <= '1;
            q.avg   <= CNT_W'(LINE_NOM);
        end else begin
            q <= d;
        end
    end

    assign avg_o = q.avg;

    // R6: a spacing equal to the estimate leaves the estimate unchanged
    a_r6_avg_fixed_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && q.since != '1 && since_plus == {1'b0, q.avg}) |=> $stable(q.avg));
endmodule

// File: rtl/csn_classify.sv
module csn_classify import csn_pkg::*; #(
    parameter int CNT_W   = 12,
    parameter int MIN_W   = 4,
    parameter int HS_W    = 8,
    parameter int V_ENTER = 2,
    parameter int V_EXIT  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             act_i,
    input  logic             win_open_i,
    input  logic [CNT_W-1:0] avg_i,
    output logic             accept_o,
    output logic             hs_o,
    output logic             vs_o
);
    localparam int HW   = $clog2(HS_W + 1);
    localparam int VMAX = (V_ENTER > V_EXIT) ? V_ENTER : V_EXIT;
    localparam int VCW  = $clog2(VMAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             took;
        logic [HW-1:0]    hcnt;
        logic [VCW-1:0]   bcnt;
        logic [VCW-1:0]   ncnt;
        logic             vs;
    } cls_st_t;

    cls_st_t     q, d;
    logic        qual, ends;
    pulse_kind_e kind;

    always_comb begin
        d        = q;
        qual     = act_i && (q.run == CNT_W'(MIN_W - 1));
        accept_o = qual && win_open_i;
        ends     = !act_i && (q.run != '0);
        kind     = ends ? classify_width(32'(q.run), 32'(avg_i), 32'(MIN_W)) : KIND_NONE;

        if (act_i) begin
            if (q.run != '1) d.run = q.run + CNT_W'(1);
        end else begin
            d.run = '0;
        end

        if (accept_o)           d.hcnt = HW'(HS_W);
        else if (q.hcnt != '0)  d.hcnt = q.hcnt - HW'(1);

        if (accept_o)  d.took = 1'b1;
        else if (ends) d.took = 1'b0;

        case (kind)
            KIND_BROAD: begin
                d.ncnt = '0;
                if (q.bcnt != VCW'(VMAX)) d.bcnt = q.bcnt + VCW'(1);
                if (q.bcnt >= VCW'(V_ENTER - 1)) d.vs = 1'b1;
            end
            KIND_LINE: begin
                if (q.took) begin
                    d.bcnt = '0;
                    if (q.ncnt != VCW'(VMAX)) d.ncnt = q.ncnt + VCW'(1);
                    if (q.ncnt >= VCW'(V_EXIT - 1)) d.vs = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign hs_o = (q.hcnt != '0);
    assign vs_o = q.vs;

    // R1: a horizontal pulse starts only after an active sample
    a_r1_hs_from_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_o) |-> $past(act_i));

    // R4: a horizontal pulse needs a run of at least the minimum width
    a_r4_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_o) |-> $past(q.run) >= CNT_W'(MIN_W - 1));

    // R5: a horizontal pulse needs the line window to be open
    a_r5_window_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_o) |-> $past(win_open_i));

    // R7: vertical flag rises only on a broad pulse end
    a_r7_vs_on_broad: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vs_o) |-> $past(kind == KIND_BROAD));

    // R8: vertical flag falls only on an accepted normal pulse end
    a_r8_vs_off_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(vs_o) |-> $past(kind == KIND_LINE && q.took));
endmodule

// File: rtl/csync_normalizer.sv
module csync_normalizer #(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_W       = 4,
    parameter int HS_W        = 8,
    parameter int LINE_NOM    = 100,
    parameter int AVG_SH      = 3,
    parameter int POL_LINES   = 4,
    parameter int V_ENTER     = 2,
    parameter int V_EXIT      = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    input  logic ext_inh_i,
    output logic hs_o,
    output logic vs_o,
    output logic inh_o
);
    logic             s_sync, act, accept, win_open;
    logic [CNT_W-1:0] avg;

    csn_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (sync_i),
        .q_o   (s_sync)
    );

    csn_polarity #(.CNT_W(CNT_W), .POL_LINES(POL_LINES)) u_pol (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .s_i   (s_sync),
        .act_o (act)
    );

    csn_window #(.CNT_W(CNT_W), .LINE_NOM(LINE_NOM), .AVG_SH(AVG_SH)) u_win (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .accept_i  (accept),
        .win_open_o(win_open),
        .avg_o     (avg)
    );

    csn_classify #(.CNT_W(CNT_W), .MIN_W(MIN_W), .HS_W(HS_W),
                   .V_ENTER(V_ENTER), .V_EXIT(V_EXIT)) u_cls (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .act_i     (act),
        .win_open_i(win_open),
        .avg_i     (avg),
        .accept_o  (accept),
        .hs_o      (hs_o),
        .vs_o      (vs_o)
    );

    assign inh_o = vs_o | ext_inh_i;
endmodule

// File: tb/csync_normalizer_test.sv
module csync_normalizer_test;
    localparam int MIN_W = 4;
    localparam int HS_W  = 8;
    localparam int SYNC  = 2;
    localparam int LAT   = SYNC + MIN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x_act = 1'b0;
    logic neg_tb = 1'b0;
    logic ext_inh = 1'b0;
    logic sync_in;
    logic hs, vs, inh;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit chk_en = 1'b1;
    int exp_q[$];

    assign sync_in = x_act ^ neg_tb;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    csync_normalizer uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .sync_i   (sync_in),
        .ext_inh_i(ext_inh),
        .hs_o     (hs),
        .vs_o     (vs),
        .inh_o    (inh)
    );

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // driver: one active pulse then an idle gap, optional expected hs edge
    task automatic send(input int width, input int gap, input bit exp_hs);
        @(negedge clk);
        x_act = 1'b1;
        if (exp_hs && chk_en) exp_q.push_back(cyc + LAT);
        repeat (width) @(negedge clk);
        x_act = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // monitor: scoreboard of hs rising edges and widths (R1)
    int  rise_cyc = 0;
    bit  hs_prev = 1'b0;
    bit  tracked = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hs && !hs_prev) begin
                rise_cyc = cyc;
                tracked  = chk_en;
                if (chk_en) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1/R5 unexpected hs edge", cyc, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(cyc == e, "R1 hs rise cycle", cyc, e);
                    end
                end
            end
            if (!hs && hs_prev && tracked)
                chk((cyc - rise_cyc) == HS_W, "R1 hs width", cyc - rise_cyc, HS_W);
            hs_prev = hs;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(hs == 1'b0 && vs == 1'b0 && inh == 1'b0, "R10 outputs in reset", {hs, vs, inh}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hs == 1'b0 && vs == 1'b0 && inh == 1'b0, "R10 outputs after reset", {hs, vs, inh}, 0);

        // plain lines, active high
        for (int i = 0; i < 6; i++) send(8, 92, 1'b1);
        chk(vs == 1'b0, "R7 no vertical on normal lines", vs, 0);

        // R5: equalizing pulses at half line dropped
        for (int i = 0; i < 4; i++) begin
            send(6, 44, 1'b1);
            send(6, 44, 1'b0);
        end
        chk(exp_q.size() == 0, "R5 equalizing produced no extra edge", exp_q.size(), 0);
        chk(vs == 1'b0, "R8 rejected pulses leave vertical low", vs, 0);

        // R4: narrow pulse and glitch mid line
        send(8, 42, 1'b1);
        send(3, 47, 1'b0);
        send(8, 40, 1'b1);
        send(2, 50, 1'b0);
        chk(exp_q.size() == 0, "R4 short pulses ignored", exp_q.size(), 0);
        chk(vs == 1'b0, "R4 short pulses leave vertical low", vs, 0);

        // R7: broad serrations
        send(35, 65, 1'b1);
        chk(vs == 1'b0, "R7 one broad pulse not enough", vs, 0);
        send(35, 65, 1'b1);
        chk(vs == 1'b1, "R7 vertical after two broad", vs, 1);
        chk(inh == 1'b1, "R9 inhibit follows vertical", inh, 1);
        ext_inh = 1'b1;
        send(35, 65, 1'b1);
        chk(inh == 1'b1, "R9 inhibit with both sources", inh, 1);
        ext_inh = 1'b0;
        #1;
        chk(inh == 1'b1, "R9 inhibit held by vertical alone", inh, 1);

        // R8: exit after two accepted normal pulses
        send(8, 92, 1'b1);
        chk(vs == 1'b1, "R8 one normal pulse keeps vertical", vs, 1);
        send(8, 92, 1'b1);
        chk(vs == 1'b0, "R8 vertical cleared after two normal", vs, 0);
        chk(inh == 1'b0, "R9 inhibit released", inh, 0);

        // R9: external inhibit alone
        @(negedge clk);
        ext_inh = 1'b1;
        #1;
        chk(inh == 1'b1, "R9 external inhibit immediate", inh, 1);
        chk(vs == 1'b0, "R9 external inhibit does not set vertical", vs, 0);
        ext_inh = 1'b0;
        #1;
        chk(inh == 1'b0, "R9 external inhibit released", inh, 0);

        // R3: three inverted lines must not flip polarity
        chk_en = 1'b0;
        neg_tb = 1'b1;
        for (int i = 0; i < 3; i++) send(8, 92, 1'b0);
        neg_tb = 1'b0;
        for (int i = 0; i < 2; i++) send(8, 92, 1'b0);
        chk_en = 1'b1;
        for (int i = 0; i < 4; i++) send(8, 92, 1'b1);
        chk(vs == 1'b0, "R3 polarity kept, vertical cleared", vs, 0);

        // R2: sustained inverted input flips polarity
        chk_en = 1'b0;
        neg_tb = 1'b1;
        for (int i = 0; i < 8; i++) send(8, 92, 1'b0);
        chk_en = 1'b1;
        for (int i = 0; i < 4; i++) send(8, 92, 1'b1);
        chk(vs == 1'b0, "R2 inverted input normalised", vs, 0);
        chk(exp_q.size() == 0, "R2 all inverted lines produced hs", exp_q.size(), 0);

        // R6: estimate tracks a longer line, closing the window at 80
        for (int i = 0; i < 20; i++) send(8, 112, 1'b1);
        send(8, 72, 1'b1);
        send(8, 32, 1'b0);
        send(8, 112, 1'b1);
        chk(exp_q.size() == 0, "R6 edge at 80 rejected after tracking 120", exp_q.size(), 0);
        send(8, 112, 1'b1);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R1 no missing hs edge", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule